// File: doc/BRIEF.md
# Interlaced Dual-Path Instruction Sequencer

This block fetches and sequences instructions for a core whose instruction memory returns a pair of words on every access: the word at the even address and the word at the odd address of one double word. In sequential mode it issues the even word and then the odd word, one instruction per cycle. The memory is read combinationally from the double-word fetch address. Each slot comes with predecoded flags from the memory side: a plain branch, a conditional test, and a branch-to-interlaced, along with a word target address.

A conditional test opens an interlaced region at the next double word. In that region the odd words hold the path taken when the condition is true, and the even words hold the path taken when it is false. Once the condition result is valid, only the matching lane of each double word is issued and the other lane is dropped. A branch-to-interlaced instruction jumps into such a region and picks its lane from the target's low address bit. This lets the end of one path re-enter the other path's region without copying code. Interlaced issue ends at a branch in the executing lane, which is taken. It also ends at a branch in the idle lane, in which case sequential issue resumes at the next double word.

Issue is registered. The issued word, its word address and a valid flag appear one clock after the double word that holds them is presented.

Top module: `ilv_seq`

## Requirements
- R1: While reset is asserted, iss_valid is 0 and fetch_dw equals RESET_ADDR shifted right by one (word address 8, double word 4 by default).
- R2: In sequential mode each double word issues its even word (address bit 0 = 0), then its odd word, then fetch_dw increments by one.
- R3: Every issued instruction carries the word read from the slot it came from, and iss_addr is {fetch_dw, slot}, with slot 0 = even and 1 = odd.
- R4: A plain branch (flag br) issued in sequential mode redirects fetch to its target. If the target is odd, only the odd slot of the first fetched double word is issued.
- R5: A conditional test (flag cnd) does not break sequential issue of the rest of its own double word. The interlaced region begins at the following double word.
- R6: In an interlaced region, cond_true = 1 issues the odd lane and cond_true = 0 issues the even lane. Exactly one instruction is issued per double word, and fetch_dw advances by one per double word.
- R7: If cond_valid is 0 when the first double word of a region is presented, nothing is issued and fetch_dw holds until cond_valid is 1.
- R8: A plain branch in the executing lane is issued, and sequential issue resumes at its target.
- R9: A branch or branch-to-interlaced in the idle lane ends the region. The executing-lane word of that double word is still issued, and sequential issue resumes at the even word of the next double word.
- R10: A branch-to-interlaced (flag ibr) jumps to its target and enters interlaced issue there. The lane is odd when target bit 0 is 1 and even otherwise.
- R11: When both lanes of one double word hold a branch, the executing lane's branch is taken. Within one slot the flag priority is br, then ibr, then cnd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_dw | output | AW-1 | Double-word fetch address |
| ev_word | input | IW | Even-slot instruction word |
| ev_br | input | 1 | Even slot is a plain branch |
| ev_ibr | input | 1 | Even slot is a branch-to-interlaced |
| ev_cnd | input | 1 | Even slot is a conditional test |
| ev_tgt | input | AW | Even-slot branch target (word address) |
| od_word | input | IW | Odd-slot instruction word |
| od_br | input | 1 | Odd slot is a plain branch |
| od_ibr | input | 1 | Odd slot is a branch-to-interlaced |
| od_cnd | input | 1 | Odd slot is a conditional test |
| od_tgt | input | AW | Odd-slot branch target (word address) |
| cond_valid | input | 1 | Condition outcome is available |
| cond_true | input | 1 | Condition outcome (1 selects odd lane) |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_word | output | IW | Issued instruction |
| iss_addr | output | AW | Word address of issued instruction |

## Verification
The bench targets the lane choice in both directions of the condition. A swapped lane would issue the even path when the condition is true. It checks a test placed in the odd slot, where a design that opens the region too early would skip a word. It stalls the condition while the first region double word waits, where a design that guesses would issue a word or move fetch_dw. It also covers entering a region through a branch-to-interlaced aimed at an odd target, a branch sitting in the idle lane, and branches in both lanes at once. A design that ignores the idle lane would run past the end of the path. One that gets the priority wrong would jump to the idle lane's target.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    M_SEQ  = 2'd0,
    M_PEND = 2'd1,
    M_ILV  = 2'd2
  } mode_e;

  typedef struct packed {
    logic br;
    logic ibr;
    logic cnd;
  } pdec_t;
endpackage

// File: rtl/ilv_lane_pick.sv
module ilv_lane_pick
  import ilv_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          sel,
  input  pdec_t         ev_f,
  input  pdec_t         od_f,
  input  logic [AW-1:0] ev_t,
  input  logic [AW-1:0] od_t,
  output pdec_t         f,
  output logic [AW-1:0] t
);
  always_comb begin
    f = sel ? od_f : ev_f;
    t = sel ? od_t : ev_t;
  end
endmodule

// File: rtl/ilv_next.sv
module ilv_next
  import ilv_pkg::*;
#(
  parameter int AW = 16,
  localparam int DW = AW - 1
) (
  input  mode_e         mode_q,
  input  logic          slot_q,
  input  logic          lane_q,
  input  logic          arm_q,
  input  logic [DW-1:0] dw_q,
  input  pdec_t         ev_f,
  input  pdec_t         od_f,
  input  logic [AW-1:0] ev_t,
  input  logic [AW-1:0] od_t,
  input  logic          cond_valid,
  input  logic          cond_true,
  output mode_e         mode_d,
  output logic          slot_d,
  output logic          lane_d,
  output logic          arm_d,
  output logic [DW-1:0] dw_d,
  output logic          issue,
  output logic          sel
);
  logic          lane_eff;
  pdec_t         cur_f, idle_f;
  logic [AW-1:0] cur_t, idle_t;
  logic [DW-1:0] dw_inc;

  assign lane_eff = (mode_q == M_PEND) ? cond_true : lane_q;
  assign sel      = (mode_q == M_SEQ) ? slot_q : lane_eff;
  assign dw_inc   = dw_q + DW'(1);

  ilv_lane_pick #(.AW(AW)) u_cur (
    .sel(sel), .ev_f(ev_f), .od_f(od_f), .ev_t(ev_t), .od_t(od_t),
    .f(cur_f), .t(cur_t)
  );

  ilv_lane_pick #(.AW(AW)) u_idle (
    .sel(~sel), .ev_f(ev_f), .od_f(od_f), .ev_t(ev_t), .od_t(od_t),
    .f(idle_f), .t(idle_t)
  );

  always_comb begin
    mode_d = mode_q;
    slot_d = slot_q;
    lane_d = lane_q;
    arm_d  = arm_q;
    dw_d   = dw_q;
    issue  = 1'b0;
    if (mode_q == M_SEQ) begin
      issue = 1'b1;
      arm_d = 1'b0;
      if (cur_f.br) begin
        dw_d   = cur_t[AW-1:1];
        slot_d = cur_t[0];
      end else if (cur_f.ibr) begin
        dw_d   = cur_t[AW-1:1];
        mode_d = M_ILV;
        lane_d = cur_t[0];
        slot_d = 1'b0;
      end else if (!slot_q) begin
        slot_d = 1'b1;
        arm_d  = cur_f.cnd;
      end else begin
        dw_d   = dw_inc;
        slot_d = 1'b0;
        mode_d = (cur_f.cnd || arm_q) ? M_PEND : M_SEQ;
      end
    end else if (mode_q == M_ILV || cond_valid) begin
      issue  = 1'b1;
      lane_d = lane_eff;
      slot_d = 1'b0;
      arm_d  = 1'b0;
      if (cur_f.br) begin
        dw_d   = cur_t[AW-1:1];
        slot_d = cur_t[0];
        mode_d = M_SEQ;
      end else if (cur_f.ibr) begin
        dw_d   = cur_t[AW-1:1];
        lane_d = cur_t[0];
        mode_d = M_ILV;
      end else if (cur_f.cnd) begin
        dw_d   = dw_inc;
        mode_d = M_PEND;
      end else if (idle_f.br || idle_f.ibr) begin
        dw_d   = dw_inc;
        mode_d = M_SEQ;
      end else begin
        dw_d   = dw_inc;
        mode_d = M_ILV;
      end
    end
  end

  logic unused_idle;
  assign unused_idle = idle_f.cnd ^ (^idle_t);
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          IW         = 32,
  parameter logic [15:0] RESET_ADDR = 16'h0008,
  localparam int         DW         = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] fetch_dw,
  input  logic [IW-1:0] ev_word,
  input  logic          ev_br,
  input  logic          ev_ibr,
  input  logic          ev_cnd,
  input  logic [AW-1:0] ev_tgt,
  input  logic [IW-1:0] od_word,
  input  logic          od_br,
  input  logic          od_ibr,
  input  logic          od_cnd,
  input  logic [AW-1:0] od_tgt,
  input  logic          cond_valid,
  input  logic          cond_true,
  output logic          iss_valid,
  output logic [IW-1:0] iss_word,
  output logic [AW-1:0] iss_addr
);
  localparam logic [AW-1:0] RST_W = AW'(RESET_ADDR);

  logic [1:0]    rs_q;
  logic          srst_n;
  mode_e         mode_q, mode_d;
  logic          slot_q, slot_d, lane_q, lane_d, arm_q, arm_d;
  logic [DW-1:0] dw_q, dw_d;
  logic          issue, sel;
  pdec_t         ev_f, od_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign ev_f = '{br: ev_br, ibr: ev_ibr, cnd: ev_cnd};
  assign od_f = '{br: od_br, ibr: od_ibr, cnd: od_cnd};

  ilv_next #(.AW(AW)) u_next (
    .mode_q(mode_q), .slot_q(slot_q), .lane_q(lane_q), .arm_q(arm_q),
    .dw_q(dw_q), .ev_f(ev_f), .od_f(od_f), .ev_t(ev_tgt), .od_t(od_tgt),
    .cond_valid(cond_valid), .cond_true(cond_true),
    .mode_d(mode_d), .slot_d(slot_d), .lane_d(lane_d), .arm_d(arm_d),
    .dw_d(dw_d), .issue(issue), .sel(sel)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= M_SEQ;
      slot_q <= RST_W[0];
      lane_q <= 1'b0;
      arm_q  <= 1'b0;
      dw_q   <= RST_W[AW-1:1];
    end else begin
      mode_q <= mode_d;
      slot_q <= slot_d;
      lane_q <= lane_d;
      arm_q  <= arm_d;
      dw_q   <= dw_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      iss_valid <= 1'b0;
      iss_word  <= '0;
      iss_addr  <= '0;
    end else begin
      iss_valid <= issue;
      if (issue) begin
        iss_word <= sel ? od_word : ev_word;
        iss_addr <= {dw_q, sel};
      end
    end
  end

  assign fetch_dw = dw_q;
endmodule

// File: rtl/ilv_seq_chk.sv
module ilv_seq_chk
  import ilv_pkg::*;
#(
  parameter int AW = 16,
  localparam int DW = AW - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_n,
  input mode_e         mode_q,
  input logic          slot_q,
  input logic          lane_q,
  input logic [DW-1:0] fetch_dw,
  input logic          ev_br,
  input logic          ev_ibr,
  input logic          ev_cnd,
  input logic          ev_tgt0,
  input logic          od_br,
  input logic          od_ibr,
  input logic          od_cnd,
  input logic          cond_valid,
  input logic          iss_valid
);
  logic x_br, x_ibr, x_cnd, i_br;
  assign x_br  = lane_q ? od_br  : ev_br;
  assign x_ibr = lane_q ? od_ibr : ev_ibr;
  assign x_cnd = lane_q ? od_cnd : ev_cnd;
  assign i_br  = lane_q ? (ev_br | ev_ibr) : (od_br | od_ibr);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !iss_valid);

  a_r2_even_then_odd: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == M_SEQ && !slot_q && !ev_br && !ev_ibr)
    |=> ($stable(fetch_dw) && slot_q));

  a_r6_ilv_advance: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == M_ILV && !x_br && !x_ibr)
    |=> (fetch_dw == DW'($past(fetch_dw) + DW'(1))));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == M_PEND && !cond_valid)
    |=> ($stable(fetch_dw) && !iss_valid));

  a_r9_idle_branch_ends: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == M_ILV && !x_br && !x_ibr && !x_cnd && i_br)
    |=> (mode_q == M_SEQ && !slot_q));

  a_r10_ibr_lane: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q == M_SEQ && !slot_q && ev_ibr && !ev_br)
    |=> (mode_q == M_ILV && lane_q == $past(ev_tgt0)));
endmodule

bind ilv_seq ilv_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .mode_q(mode_q),
  .slot_q(slot_q), .lane_q(lane_q), .fetch_dw(fetch_dw),
  .ev_br(ev_br), .ev_ibr(ev_ibr), .ev_cnd(ev_cnd), .ev_tgt0(ev_tgt[0]),
  .od_br(od_br), .od_ibr(od_ibr), .od_cnd(od_cnd),
  .cond_valid(cond_valid), .iss_valid(iss_valid)
);

// File: tb/ilv_seq_bench.sv
`timescale 1ns/1ps
module ilv_seq_bench;
  localparam int AW = 16;
  localparam int IW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-2:0] fetch_dw;
  logic [IW-1:0] ev_word, od_word, iss_word;
  logic ev_br, ev_ibr, ev_cnd, od_br, od_ibr, od_cnd;
  logic [AW-1:0] ev_tgt, od_tgt, iss_addr;
  logic cond_valid = 1'b1, cond_true = 1'b1;
  logic iss_valid;

  logic [IW-1:0] m_word [64];
  logic          m_br [64], m_ibr [64], m_cnd [64];
  logic [AW-1:0] m_tgt [64];
  logic [5:0] ea, oa;

  int total = 0, bad = 0, n_log = 0, wbad = 0;
  int log_a [64];

  always #2.5 clk = ~clk;

  assign ea = {fetch_dw[4:0], 1'b0};
  assign oa = {fetch_dw[4:0], 1'b1};
  assign ev_word = m_word[ea]; assign od_word = m_word[oa];
  assign ev_br = m_br[ea];  assign od_br = m_br[oa];
  assign ev_ibr = m_ibr[ea]; assign od_ibr = m_ibr[oa];
  assign ev_cnd = m_cnd[ea]; assign od_cnd = m_cnd[oa];
  assign ev_tgt = m_tgt[ea]; assign od_tgt = m_tgt[oa];

  ilv_seq #(.AW(AW), .IW(IW), .RESET_ADDR(16'h0008)) u_ilv_seq (
    .clk(clk), .rst_n(rst_n), .fetch_dw(fetch_dw),
    .ev_word(ev_word), .ev_br(ev_br), .ev_ibr(ev_ibr), .ev_cnd(ev_cnd),
    .ev_tgt(ev_tgt), .od_word(od_word), .od_br(od_br), .od_ibr(od_ibr),
    .od_cnd(od_cnd), .od_tgt(od_tgt), .cond_valid(cond_valid),
    .cond_true(cond_true), .iss_valid(iss_valid), .iss_word(iss_word),
    .iss_addr(iss_addr)
  );

  always @(negedge clk) begin
    if (rst_n && iss_valid && n_log < 64) begin
      log_a[n_log] = int'(iss_addr);
      if (iss_word != m_word[iss_addr[5:0]]) wbad = wbad + 1;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 64; a++) begin
      m_word[a] = 32'hA000_0000 + a;
      m_br[a] = 1'b0; m_ibr[a] = 1'b0; m_cnd[a] = 1'b0; m_tgt[a] = '0;
    end
  endtask

  task automatic start(input int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    n_log = 0; wbad = 0;
    repeat (2) @(negedge clk);
    chk(!iss_valid, "R1 valid in reset", int'(iss_valid), 0);
    chk(fetch_dw == 15'd4, "R1 reset fetch", int'(fetch_dw), 4);
    rst_n = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic cmp_log(input string req, input int exp [8], input int n);
    for (int i = 0; i < n; i++)
      chk(n_log > i && log_a[i] == exp[i], req, (n_log > i) ? log_a[i] : -1, exp[i]);
    chk(wbad == 0, "R3 issued word matches slot", wbad, 0);
  endtask

  task automatic t_seq();
    clear_mem(); cond_valid = 1'b1; cond_true = 1'b1;
    start(12);
    cmp_log("R2 sequential order", '{8, 9, 10, 11, 12, 13, 14, 15}, 8);
  endtask

  task automatic t_branch_odd();
    clear_mem(); m_br[9] = 1'b1; m_tgt[9] = 16'd21;
    start(12);
    cmp_log("R4 branch to odd target", '{8, 9, 21, 22, 23, 0, 0, 0}, 5);
  endtask

  task automatic t_cond_true();
    clear_mem(); m_cnd[8] = 1'b1; m_br[14] = 1'b1; m_tgt[14] = 16'd30;
    cond_valid = 1'b1; cond_true = 1'b1;
    start(14);
    cmp_log("R6 R9 true lane, idle branch", '{8, 9, 11, 13, 15, 16, 17, 18}, 8);
  endtask

  task automatic t_cond_false();
    clear_mem(); m_cnd[8] = 1'b1; m_br[14] = 1'b1; m_tgt[14] = 16'd30;
    cond_valid = 1'b1; cond_true = 1'b0;
    start(14);
    cmp_log("R6 R8 false lane, exec branch", '{8, 9, 10, 12, 14, 30, 31, 32}, 8);
  endtask

  task automatic t_odd_test_and_reentry();
    clear_mem(); m_cnd[9] = 1'b1; m_ibr[13] = 1'b1; m_tgt[13] = 16'd20;
    m_br[23] = 1'b1; m_tgt[23] = 16'd50;
    cond_valid = 1'b1; cond_true = 1'b1;
    start(14);
    cmp_log("R5 R10 odd test, reentry", '{8, 9, 11, 13, 20, 22, 24, 25}, 8);
  endtask

  task automatic t_ibr_odd();
    clear_mem(); m_ibr[8] = 1'b1; m_tgt[8] = 16'd13;
    m_br[16] = 1'b1; m_tgt[16] = 16'd40;
    start(12);
    cmp_log("R10 ibr odd lane", '{8, 13, 15, 17, 18, 19, 0, 0}, 6);
  endtask

  task automatic t_stall();
    clear_mem(); m_cnd[9] = 1'b1;
    cond_valid = 1'b0; cond_true = 1'b1;
    start(14);
    chk(n_log == 2, "R7 no issue while pending", n_log, 2);
    chk(fetch_dw == 15'd5, "R7 fetch held", int'(fetch_dw), 5);
    cond_valid = 1'b1;
    repeat (6) @(negedge clk);
    cmp_log("R7 resume after valid", '{8, 9, 11, 13, 15, 17, 0, 0}, 6);
  endtask

  task automatic t_both_branch();
    clear_mem(); m_cnd[9] = 1'b1;
    m_br[10] = 1'b1; m_tgt[10] = 16'd40;
    m_br[11] = 1'b1; m_tgt[11] = 16'd30;
    cond_valid = 1'b1; cond_true = 1'b1;
    start(12);
    cmp_log("R11 exec lane wins", '{8, 9, 11, 30, 31, 0, 0, 0}, 5);
  endtask

  initial begin
    clear_mem();
    t_seq();
    t_branch_odd();
    t_cond_true();
    t_cond_false();
    t_odd_test_and_reentry();
    t_ibr_odd();
    t_stall();
    t_both_branch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule